// File: doc/BRIEF.md
# Multi-Size LRU Hit Tracker

This block is a fully associative tag store with true least-recently-used replacement. It runs one tag array and measures, on the same access stream, how a family of smaller caches would have behaved. The smaller caches are every power-of-two size from a minimum up to, but not including, the real capacity. Each is a strict LRU prefix of the real recency order, so one set of tags is enough to answer all of them.

Every entry carries a residency mask with one bit per tracked size. For each size, a boundary marker points at the least-recent entry still inside that size. When an entry is promoted to most-recent, or demoted to least-recent, the affected boundaries slide by one position and the mask bits of the two entries involved are updated. A lookup returns a hit flag, the entry index and the residency mask of the hit entry. A running counter totals all lookups, and for each size a pair of counters totals its hits and misses. An invalidate request removes a matching entry and parks it at the least-recent position.

Top module: `lru_trk`

## Requirements
- R1: A lookup presented in one cycle produces `rspValid`, `rspHit`, `rspIdx` and `rspMask` at the next clock edge. `rspValid` is low after any cycle without a lookup.
- R2: Replacement is true LRU. A hit moves the entry to the most-recent position. A miss with `lkpAlloc` set writes the tag into the least-recent entry and makes it most-recent, and `rspIdx` reports that entry. After reset, entry i sits at recency position i, so the first allocation uses entry ENTRIES-1.
- R3: On a hit, bit k of `rspMask` is set exactly when the entry's recency position before the access (0 = most recent) is below MIN_ENTRIES·2^k. Bit 0 is the smallest tracked size. On a miss, `rspMask` is zero.
- R4: The number of tracked sizes is log2(ENTRIES) − log2(MIN_ENTRIES), or zero when MIN_ENTRIES is not below ENTRIES. `rspMask` is 32 bits wide and its bits at and above that count are always zero. Elaboration fails if the count exceeds 32, if a size is not a power of two, or if MIN_ENTRIES is below 2.
- R5: Each lookup adds one to `accCnt`. For each tracked size k, the lookup adds one to `hitCnt[k]` if bit k of `rspMask` is set, and one to `missCnt[k]` otherwise, so a real miss counts as a miss in every size.
- R6: A miss with `lkpAlloc` low changes no tag, validity or recency state.
- R7: An invalidate whose tag matches a valid entry clears that entry and moves it to the least-recent position, so the next allocation reuses it. An invalidate that matches nothing, or that arrives in the same cycle as a lookup, has no effect.
- R8: During and after reset, all entries are invalid, all counters are zero and `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkpValid | input | 1 | Lookup request |
| lkpTag | input | TAG_W | Tag to look up |
| lkpAlloc | input | 1 | Allocate the tag on a miss |
| invValid | input | 1 | Invalidate request |
| invTag | input | TAG_W | Tag to invalidate |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Lookup hit in the real store |
| rspIdx | output | log2(ENTRIES) | Hit entry, or the entry allocated on a miss |
| rspMask | output | 32 | Tracked sizes that would have hit |
| accCnt | output | CNT_W | Total lookups |
| hitCnt | output | TRK·CNT_W | Per-size hit counters, size k in slice k |
| missCnt | output | TRK·CNT_W | Per-size miss counters, size k in slice k |

## Verification
Every lookup result and every counter update lands at the first rising edge after the request. The bench drives each request on a falling edge and reads all outputs on the next falling edge, exactly one edge later. An invalidate has no output of its own. Its effect is judged through the hit, index and mask returned by lookups issued afterwards. Expected values come from a recency list kept in the bench, which is updated at the same point in each request as the block's state.

// File: rtl/lru_trk_pkg.sv
package lru_trk_pkg;
  localparam int MASK_W = 32;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_PROMOTE,
    OP_DEMOTE
  } opKind_e;

  typedef struct packed {
    opKind_e op;
    logic    wrTag;
  } dpStrobe_t;
endpackage

// File: rtl/lru_trk_store.sv
module lru_trk_store
  import lru_trk_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int MIN_ENTRIES = 2,
  parameter int TAG_W       = 20,
  parameter int NUM_TRK     = 3,
  parameter int TRK_DIM     = 3,
  localparam int IDX_W      = $clog2(ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpStrobe_t                         strobe,
  input  logic [IDX_W-1:0]                  tgtIdx,
  input  logic [TAG_W-1:0]                  newTag,
  output logic [ENTRIES-1:0][TAG_W-1:0]     tagQ,
  output logic [ENTRIES-1:0]                validQ,
  output logic [ENTRIES-1:0][IDX_W-1:0]     rankQ,
  output logic [ENTRIES-1:0][MASK_W-1:0]    maskQ,
  output logic [TRK_DIM-1:0][IDX_W-1:0]     bndQ
);
  logic [ENTRIES-1:0][TAG_W-1:0]  nTag;
  logic [ENTRIES-1:0]             nValid;
  logic [ENTRIES-1:0][IDX_W-1:0]  nRank;
  logic [ENTRIES-1:0][MASK_W-1:0] nMask;
  logic [TRK_DIM-1:0][IDX_W-1:0]  nBnd;
  logic [IDX_W-1:0]               tgtRank;
  logic [MASK_W-1:0]              tgtMask;

  // Entry currently holding recency position r
  function automatic logic [IDX_W-1:0] atRank(input logic [IDX_W-1:0] r);
    logic [IDX_W-1:0] found;
    found = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rankQ[i] == r) found = IDX_W'(i);
    return found;
  endfunction

  assign tgtRank = rankQ[tgtIdx];
  assign tgtMask = maskQ[tgtIdx];

  always_comb begin
    nTag   = tagQ;
    nValid = validQ;
    nRank  = rankQ;
    nMask  = maskQ;
    nBnd   = bndQ;
    case (strobe.op)
      OP_PROMOTE: begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == tgtIdx)       nRank[i] = '0;
          else if (rankQ[i] < tgtRank)   nRank[i] = rankQ[i] + 1'b1;
        end
        for (int k = 0; k < NUM_TRK; k++) begin
          if (!tgtMask[k]) begin
            // size k did not hold the entry: its last member drops out
            nMask[bndQ[k]][k] = 1'b0;
            nMask[tgtIdx][k]  = 1'b1;
            nBnd[k]           = atRank(IDX_W'((MIN_ENTRIES << k) - 2));
          end else if (tgtRank == IDX_W'((MIN_ENTRIES << k) - 1)) begin
            nBnd[k] = atRank(IDX_W'((MIN_ENTRIES << k) - 2));
          end
        end
        if (strobe.wrTag) begin
          nTag[tgtIdx]   = newTag;
          nValid[tgtIdx] = 1'b1;
        end
      end
      OP_DEMOTE: begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == tgtIdx)       nRank[i] = IDX_W'(ENTRIES - 1);
          else if (rankQ[i] > tgtRank)   nRank[i] = rankQ[i] - 1'b1;
        end
        for (int k = 0; k < NUM_TRK; k++) begin
          if (tgtMask[k]) begin
            // first entry outside size k moves in
            nMask[atRank(IDX_W'(MIN_ENTRIES << k))][k] = 1'b1;
            nMask[tgtIdx][k] = 1'b0;
            nBnd[k]          = atRank(IDX_W'(MIN_ENTRIES << k));
          end
        end
        nValid[tgtIdx] = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]   <= '0;
        validQ[i] <= 1'b0;
        rankQ[i]  <= IDX_W'(i);
        for (int k = 0; k < MASK_W; k++)
          maskQ[i][k] <= (k < NUM_TRK) && (i < (MIN_ENTRIES << k));
      end
      for (int k = 0; k < TRK_DIM; k++)
        bndQ[k] <= (k < NUM_TRK) ? IDX_W'((MIN_ENTRIES << k) - 1) : '0;
    end else begin
      tagQ   <= nTag;
      validQ <= nValid;
      rankQ  <= nRank;
      maskQ  <= nMask;
      bndQ   <= nBnd;
    end
  end
endmodule

// File: rtl/lru_trk_ctrl.sv
module lru_trk_ctrl
  import lru_trk_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 20,
  parameter int CNT_W   = 16,
  parameter int NUM_TRK = 3,
  parameter int TRK_DIM = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           lkpValid,
  input  logic [TAG_W-1:0]               lkpTag,
  input  logic                           lkpAlloc,
  input  logic                           invValid,
  input  logic [TAG_W-1:0]               invTag,
  input  logic [ENTRIES-1:0][TAG_W-1:0]  tagQ,
  input  logic [ENTRIES-1:0]             validQ,
  input  logic [ENTRIES-1:0][IDX_W-1:0]  rankQ,
  input  logic [ENTRIES-1:0][MASK_W-1:0] maskQ,
  output dpStrobe_t                      strobe,
  output logic [IDX_W-1:0]               tgtIdx,
  output logic [TAG_W-1:0]               newTag,
  output logic                           rspValid,
  output logic                           rspHit,
  output logic [IDX_W-1:0]               rspIdx,
  output logic [MASK_W-1:0]              rspMask,
  output logic [CNT_W-1:0]               accCnt,
  output logic [TRK_DIM-1:0][CNT_W-1:0]  hitCnt,
  output logic [TRK_DIM-1:0][CNT_W-1:0]  missCnt
);
  logic             lkpHit, invHit;
  logic [IDX_W-1:0] hitIdx, invIdx, victimIdx;
  logic [MASK_W-1:0] hitMask;

  always_comb begin
    lkpHit = 1'b0; invHit = 1'b0;
    hitIdx = '0; invIdx = '0; victimIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (validQ[i] && tagQ[i] == lkpTag) begin lkpHit = 1'b1; hitIdx = IDX_W'(i); end
      if (validQ[i] && tagQ[i] == invTag) begin invHit = 1'b1; invIdx = IDX_W'(i); end
      if (rankQ[i] == IDX_W'(ENTRIES - 1)) victimIdx = IDX_W'(i);
    end
    hitMask = lkpHit ? maskQ[hitIdx] : '0;
  end

  // lookup takes priority; an invalidate in the same cycle is dropped
  always_comb begin
    strobe = '{op: OP_NONE, wrTag: 1'b0};
    tgtIdx = '0;
    newTag = lkpTag;
    if (lkpValid) begin
      if (lkpHit) begin
        strobe.op = OP_PROMOTE;
        tgtIdx    = hitIdx;
      end else if (lkpAlloc) begin
        strobe = '{op: OP_PROMOTE, wrTag: 1'b1};
        tgtIdx = victimIdx;
      end
    end else if (invValid && invHit) begin
      strobe.op = OP_DEMOTE;
      tgtIdx    = invIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspIdx   <= '0;
      rspMask  <= '0;
      accCnt   <= '0;
      hitCnt   <= '0;
      missCnt  <= '0;
    end else begin
      rspValid <= lkpValid;
      if (lkpValid) begin
        rspHit  <= lkpHit;
        rspIdx  <= lkpHit ? hitIdx : (lkpAlloc ? victimIdx : '0);
        rspMask <= hitMask;
        accCnt  <= accCnt + 1'b1;
        for (int k = 0; k < TRK_DIM; k++) begin
          if (k < NUM_TRK) begin
            if (hitMask[k]) hitCnt[k]  <= hitCnt[k] + 1'b1;
            else            missCnt[k] <= missCnt[k] + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lru_trk.sv
module lru_trk
  import lru_trk_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int MIN_ENTRIES = 2,
  parameter int TAG_W       = 20,
  parameter int CNT_W       = 16,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int NUM_TRK    = (MIN_ENTRIES < ENTRIES) ? ($clog2(ENTRIES) - $clog2(MIN_ENTRIES)) : 0,
  localparam int TRK_DIM    = (NUM_TRK > 0) ? NUM_TRK : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lkpValid,
  input  logic [TAG_W-1:0]              lkpTag,
  input  logic                          lkpAlloc,
  input  logic                          invValid,
  input  logic [TAG_W-1:0]              invTag,
  output logic                          rspValid,
  output logic                          rspHit,
  output logic [IDX_W-1:0]              rspIdx,
  output logic [MASK_W-1:0]             rspMask,
  output logic [CNT_W-1:0]              accCnt,
  output logic [TRK_DIM-1:0][CNT_W-1:0] hitCnt,
  output logic [TRK_DIM-1:0][CNT_W-1:0] missCnt
);
  if (NUM_TRK > MASK_W) begin : g_badTrk
    $error("tracked size count exceeds residency mask width");
  end
  if ((ENTRIES & (ENTRIES - 1)) != 0 || (MIN_ENTRIES & (MIN_ENTRIES - 1)) != 0 || MIN_ENTRIES < 2) begin : g_badSize
    $error("sizes must be powers of two and minimum at least 2");
  end

  dpStrobe_t                      strobe;
  logic [IDX_W-1:0]               tgtIdx;
  logic [TAG_W-1:0]               newTag;
  logic [ENTRIES-1:0][TAG_W-1:0]  tagQ;
  logic [ENTRIES-1:0]             validQ;
  logic [ENTRIES-1:0][IDX_W-1:0]  rankQ;
  logic [ENTRIES-1:0][MASK_W-1:0] maskQ;
  logic [TRK_DIM-1:0][IDX_W-1:0]  bndQ;

  lru_trk_ctrl #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .CNT_W(CNT_W),
    .NUM_TRK(NUM_TRK), .TRK_DIM(TRK_DIM)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lkpValid(lkpValid), .lkpTag(lkpTag), .lkpAlloc(lkpAlloc),
    .invValid(invValid), .invTag(invTag),
    .tagQ(tagQ), .validQ(validQ), .rankQ(rankQ), .maskQ(maskQ),
    .strobe(strobe), .tgtIdx(tgtIdx), .newTag(newTag),
    .rspValid(rspValid), .rspHit(rspHit), .rspIdx(rspIdx), .rspMask(rspMask),
    .accCnt(accCnt), .hitCnt(hitCnt), .missCnt(missCnt)
  );

  lru_trk_store #(
    .ENTRIES(ENTRIES), .MIN_ENTRIES(MIN_ENTRIES), .TAG_W(TAG_W),
    .NUM_TRK(NUM_TRK), .TRK_DIM(TRK_DIM)
  ) u_store (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .tgtIdx(tgtIdx), .newTag(newTag),
    .tagQ(tagQ), .validQ(validQ), .rankQ(rankQ), .maskQ(maskQ), .bndQ(bndQ)
  );
endmodule

// File: rtl/lru_trk_chk.sv
module lru_trk_chk
  import lru_trk_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int MIN_ENTRIES = 2,
  parameter int CNT_W       = 16,
  parameter int NUM_TRK     = 3,
  parameter int TRK_DIM     = 3,
  localparam int IDX_W      = $clog2(ENTRIES)
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           lkpValid,
  input logic                           rspValid,
  input logic                           rspHit,
  input logic [IDX_W-1:0]               rspIdx,
  input logic [MASK_W-1:0]              rspMask,
  input logic [CNT_W-1:0]               accCnt,
  input logic [TRK_DIM-1:0][CNT_W-1:0]  hitCnt,
  input logic [TRK_DIM-1:0][CNT_W-1:0]  missCnt,
  input logic [ENTRIES-1:0][IDX_W-1:0]  rankQ,
  input logic [ENTRIES-1:0][MASK_W-1:0] maskQ,
  input logic [TRK_DIM-1:0][IDX_W-1:0]  bndQ
);
  logic [ENTRIES-1:0][ENTRIES-1:0] rankHolders;
  always_comb
    for (int r = 0; r < ENTRIES; r++)
      for (int i = 0; i < ENTRIES; i++)
        rankHolders[r][i] = (rankQ[i] == IDX_W'(r));

  p_rsp_next_r1: assert property (@(posedge clk) disable iff (!rstN) lkpValid |=> rspValid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rstN) !lkpValid |=> !rspValid);
  p_hit_mru_r2:  assert property (@(posedge clk) disable iff (!rstN) (rspValid && rspHit) |-> rankQ[rspIdx] == '0);
  p_mask_upper_r4: assert property (@(posedge clk) disable iff (!rstN) (rspMask >> NUM_TRK) == '0);
  p_acc_step_r5: assert property (@(posedge clk) disable iff (!rstN) lkpValid |=> accCnt == $past(accCnt) + 1'b1);
  p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rstN) !lkpValid |=> $stable(accCnt));

  for (genvar r = 0; r < ENTRIES; r++) begin : g_rank
    p_rank_perm_r2: assert property (@(posedge clk) disable iff (!rstN) $countones(rankHolders[r]) == 1);
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    p_entry_upper_r4: assert property (@(posedge clk) disable iff (!rstN) (maskQ[i] >> NUM_TRK) == '0);
    for (genvar k = 0; k < NUM_TRK; k++) begin : g_trk
      p_mask_rank_r3: assert property (@(posedge clk) disable iff (!rstN)
        maskQ[i][k] == (rankQ[i] < IDX_W'(MIN_ENTRIES << k)));
    end
  end

  for (genvar k = 0; k < NUM_TRK; k++) begin : g_bnd
    p_boundary_r3: assert property (@(posedge clk) disable iff (!rstN)
      rankQ[bndQ[k]] == IDX_W'((MIN_ENTRIES << k) - 1));
    p_split_r5: assert property (@(posedge clk) disable iff (!rstN)
      CNT_W'(hitCnt[k] + missCnt[k]) == accCnt);
  end
endmodule

bind lru_trk lru_trk_chk #(
  .ENTRIES(ENTRIES), .MIN_ENTRIES(MIN_ENTRIES), .CNT_W(CNT_W),
  .NUM_TRK(NUM_TRK), .TRK_DIM(TRK_DIM)
) u_chk (
  .clk(clk), .rstN(rstN), .lkpValid(lkpValid),
  .rspValid(rspValid), .rspHit(rspHit), .rspIdx(rspIdx), .rspMask(rspMask),
  .accCnt(accCnt), .hitCnt(hitCnt), .missCnt(missCnt),
  .rankQ(rankQ), .maskQ(maskQ), .bndQ(bndQ)
);

// File: tb/tb_lru_trk.sv
module tb_lru_trk;
  localparam int CLK_P   = 10;
  localparam int N       = 16;
  localparam int MINE    = 2;
  localparam int TW      = 20;
  localparam int CW      = 16;
  localparam int TRK     = $clog2(N) - $clog2(MINE);
  localparam int IW      = $clog2(N);

  logic clk = 1'b0, rstN = 1'b0;
  logic lkpValid = 1'b0, lkpAlloc = 1'b0, invValid = 1'b0;
  logic [TW-1:0] lkpTag = '0, invTag = '0;
  logic rspValid, rspHit;
  logic [IW-1:0] rspIdx;
  logic [31:0] rspMask;
  logic [CW-1:0] accCnt;
  logic [TRK-1:0][CW-1:0] hitCnt, missCnt;

  lru_trk #(.ENTRIES(N), .MIN_ENTRIES(MINE), .TAG_W(TW), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .lkpValid(lkpValid), .lkpTag(lkpTag), .lkpAlloc(lkpAlloc),
    .invValid(invValid), .invTag(invTag), .rspValid(rspValid), .rspHit(rspHit),
    .rspIdx(rspIdx), .rspMask(rspMask), .accCnt(accCnt), .hitCnt(hitCnt), .missCnt(missCnt));

  always #(CLK_P/2) clk = ~clk;

  int nChecks = 0, nErrors = 0;
  bit done = 1'b0;

  // reference recency model: refList[0] is most recent
  int refList[N];
  bit refValid[N];
  int refTag[N];
  int mAcc = 0;
  int mHit[TRK], mMiss[TRK];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int findPos(input int tag);
    for (int p = 0; p < N; p++)
      if (refValid[refList[p]] && refTag[refList[p]] == tag) return p;
    return -1;
  endfunction

  function automatic int tagAt(input int p);
    return refTag[refList[p]];
  endfunction

  task automatic toFront(input int p);
    int e = refList[p];
    for (int q = p; q > 0; q--) refList[q] = refList[q-1];
    refList[0] = e;
  endtask

  task automatic toBack(input int p);
    int e = refList[p];
    for (int q = p; q < N-1; q++) refList[q] = refList[q+1];
    refList[N-1] = e;
  endtask

  task automatic doLookup(input int tag, input bit alloc, input string req);
    int p = findPos(tag);
    bit eHit = (p >= 0);
    int eIdx = 0;
    logic [31:0] eMask = '0;
    if (eHit) begin
      eIdx = refList[p];
      for (int k = 0; k < TRK; k++) if (p < (MINE << k)) eMask[k] = 1'b1;
    end else if (alloc) eIdx = refList[N-1];
    mAcc++;
    for (int k = 0; k < TRK; k++) if (eMask[k]) mHit[k]++; else mMiss[k]++;
    lkpValid = 1'b1; lkpTag = TW'(tag); lkpAlloc = alloc;
    @(negedge clk);
    lkpValid = 1'b0; lkpAlloc = 1'b0;
    chk(rspValid === 1'b1, "R1", "rspValid", rspValid, 1);
    chk(rspHit === eHit, req, "rspHit", rspHit, eHit);
    if (eHit || alloc) chk(rspIdx === IW'(eIdx), req, "rspIdx", rspIdx, eIdx);
    chk(rspMask === eMask, "R3", "rspMask", rspMask, eMask);
    chk(accCnt === CW'(mAcc), "R5", "accCnt", accCnt, mAcc);
    for (int k = 0; k < TRK; k++) begin
      chk(hitCnt[k] === CW'(mHit[k]), "R5", "hitCnt", hitCnt[k], mHit[k]);
      chk(missCnt[k] === CW'(mMiss[k]), "R5", "missCnt", missCnt[k], mMiss[k]);
    end
    if (eHit) toFront(p);
    else if (alloc) begin
      refValid[eIdx] = 1'b1; refTag[eIdx] = tag; toFront(N-1);
    end
  endtask

  task automatic doInvalidate(input int tag);
    int p = findPos(tag);
    invValid = 1'b1; invTag = TW'(tag);
    @(negedge clk);
    invValid = 1'b0;
    chk(rspValid === 1'b0, "R1", "rspValid idle", rspValid, 0);
    if (p >= 0) begin refValid[refList[p]] = 1'b0; toBack(p); end
  endtask

  task automatic tReset();
    chk(rspValid === 1'b0, "R8", "rspValid in reset", rspValid, 0);
    chk(accCnt === '0, "R8", "accCnt in reset", accCnt, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rspValid === 1'b0, "R8", "rspValid after reset", rspValid, 0);
    chk(accCnt === '0, "R8", "accCnt after reset", accCnt, 0);
    for (int k = 0; k < TRK; k++) begin
      chk(hitCnt[k] === '0, "R8", "hitCnt after reset", hitCnt[k], 0);
      chk(missCnt[k] === '0, "R8", "missCnt after reset", missCnt[k], 0);
    end
    doLookup('h55, 1'b0, "R8");
  endtask

  task automatic tFill();
    doLookup('h100, 1'b1, "R2");
    chk(rspIdx === IW'(N-1), "R2", "first allocation entry", rspIdx, N-1);
    for (int i = 1; i < N; i++) doLookup('h100 + i, 1'b1, "R2");
    for (int i = 0; i < N; i++) chk(refValid[i], "R2", "model fill", refValid[i], 1);
  endtask

  task automatic tRecency();
    int pos[8] = '{0, 1, 2, 3, 4, 7, 8, 15};
    for (int j = 0; j < 8; j++) doLookup(tagAt(pos[j]), 1'b0, "R3");
    chk(rspMask === '0, "R4", "no bits beyond tracked sizes", rspMask, 0);
    doLookup(tagAt(0), 1'b0, "R4");
    chk(rspMask === 32'h7, "R4", "MRU hits in all tracked sizes", rspMask, 7);
  endtask

  task automatic tMissNoAlloc();
    int t5 = tagAt(5);
    doLookup('h9999, 1'b0, "R6");
    doLookup('h9999, 1'b0, "R6");
    doLookup(t5, 1'b0, "R6");
  endtask

  task automatic tEvict();
    int old = tagAt(N-1);
    doLookup('h777, 1'b1, "R2");
    doLookup(old, 1'b0, "R2");
    doLookup('h777, 1'b0, "R2");
  endtask

  task automatic tInvalidate();
    int t0 = tagAt(0);
    int e0 = refList[0];
    doInvalidate(t0);
    doLookup(t0, 1'b0, "R7");
    doLookup(tagAt(0), 1'b0, "R7");
    doLookup('h888, 1'b1, "R7");
    chk(rspIdx === IW'(e0), "R7", "invalidated entry reused", rspIdx, e0);
    doInvalidate('h4242);
    doLookup(tagAt(3), 1'b0, "R7");
  endtask

  task automatic tInvWithLookup();
    int ta = tagAt(6);
    int tb = tagAt(2);
    int pa = findPos(ta);
    invValid = 1'b1; invTag = TW'(tb);
    lkpValid = 1'b1; lkpTag = TW'(ta); lkpAlloc = 1'b0;
    mAcc++;
    for (int k = 0; k < TRK; k++) if (pa < (MINE << k)) mHit[k]++; else mMiss[k]++;
    @(negedge clk);
    invValid = 1'b0; lkpValid = 1'b0;
    chk(rspHit === 1'b1, "R7", "lookup alongside invalidate", rspHit, 1);
    toFront(pa);
    doLookup(tb, 1'b0, "R7");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin refList[i] = i; refValid[i] = 1'b0; refTag[i] = 0; end
    for (int k = 0; k < TRK; k++) begin mHit[k] = 0; mMiss[k] = 0; end
    repeat (3) @(negedge clk);
    tReset();
    tFill();
    tRecency();
    tMissNoAlloc();
    tEvict();
    tInvalidate();
    tInvWithLookup();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule